// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel position inside a tiled two-dimensional container into the 32-bit address that a memory client issues to reach that pixel through a chosen view. Each request carries a pixel-format code, a view-orientation code and an x/y coordinate. The generated address carries the orientation in its top three bits and the format in the two bits below them. The low 27 bits hold a linear offset. The shape of that offset depends on the format, on mirroring and on axis swapping.

Each format gives up a fixed number of low coordinate bits. The usable x width is 14 minus the x drop, and the usable y width is 13 minus the y drop. A coordinate that does not fit its usable width is rejected. Mirroring inverts a coordinate within its usable width. An axis swap exchanges which coordinate forms the upper part of the offset. Alongside the address, the block reports the line stride of the selected view.

A request is taken whenever `in_valid` is high. The address, the reject flag and the stride are registered. They appear with a one-clock `out_valid` pulse on the edge after the request and are held until the next request. A two-state controller paces the outputs. In `S_IDLE` no result is being presented. In `S_EMIT` a fresh result is on the outputs. The controller moves from `S_IDLE` to `S_EMIT` on a request (transition "accept"). It stays in `S_EMIT` while requests keep arriving back to back ("chain"). It returns to `S_IDLE` on the first cycle without one ("drain").

Top module: `tva_addr_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low after any cycle in which it was low.
- R2: For an accepted coordinate, address bits [28:27] equal the format code: 0 = 8-bit tiled, 1 = 16-bit tiled, 2 = 32-bit tiled, 3 = page mode.
- R3: For an accepted coordinate, address bits [31:29] equal the 3-bit orientation code.
- R4: If x exceeds its usable mask or y exceeds its usable mask, the address is 0 and `invalid` is 1. Otherwise `invalid` is 0.
- R5: The dropped bits (x, y) per format are: 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (6,6). The x mask is 2^(14-xdrop)-1 and the y mask is 2^(13-ydrop)-1.
- R6: Orientation bit 0 set replaces x with x XOR its mask before the offset is formed.
- R7: Orientation bit 1 set replaces y with y XOR its mask before the offset is formed.
- R8: With orientation bit 2 clear, the offset is y·2^(x width) + x.
- R9: With orientation bit 2 set, the offset is x·2^(y width) + y.
- R10: The offset is shifted left by (xdrop + ydrop) to form address bits [26:0].
- R11: The stride is 2^(13 + xdrop) when orientation bit 2 is set, and 2^(14 + ydrop) otherwise. It is reported even for rejected coordinates.
- R12: After reset, `out_valid`, `addr`, `invalid` and `stride` are all 0.
- R13: Without `in_valid`, `addr`, `invalid` and `stride` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Pixel-format code |
| orient | input | 3 | Orientation: bit0 x-invert, bit1 y-invert, bit2 axis swap |
| x | input | 16 | Pixel column |
| y | input | 16 | Pixel row |
| out_valid | output | 1 | One-cycle result pulse |
| addr | output | 32 | Composed view address |
| invalid | output | 1 | Coordinate rejected |
| stride | output | 32 | Line stride of the selected view |

## Verification
The test coordinates are chosen so that each requirement shows a distinct effect at the outputs. Asymmetric coordinates are driven through all eight orientations. This distinguishes x-invert from y-invert, and a swapped composition from an unswapped one. Coordinates set exactly to each format's mask, and one above it on each axis separately, confirm the per-format widths and the rejection rule. Back-to-back requests followed by idle cycles exercise the pacing and the hold behaviour. Every output is compared against a behavioural model computed with integer arithmetic.

// File: rtl/tva_pkg.sv
package tva_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } fmt_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } st_e;

    // Low x bits given up by a format.
    function automatic int unsigned drop_x(input logic [1:0] f, input int unsigned slot_w_bits);
        unique case (f)
            FMT_B8, FMT_B16: drop_x = 0;
            FMT_B32:         drop_x = 1;
            default:         drop_x = slot_w_bits;
        endcase
    endfunction

    // Low y bits given up by a format.
    function automatic int unsigned drop_y(input logic [1:0] f, input int unsigned slot_h_bits);
        unique case (f)
            FMT_B8:           drop_y = 0;
            FMT_B16, FMT_B32: drop_y = 1;
            default:          drop_y = slot_h_bits;
        endcase
    endfunction

endpackage

// File: rtl/tva_range.sv
module tva_range
    import tva_pkg::*;
#(
    parameter int CW      = 14,
    parameter int CH      = 13,
    parameter int COORD_W = 16,
    parameter int SWB     = 6,
    parameter int SHB     = 6
) (
    input  logic [1:0]         fmt,
    input  logic [2:0]         orient,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [CW-1:0]      x_m,
    output logic [CH-1:0]      y_m,
    output logic [4:0]         xbits,
    output logic [4:0]         ybits,
    output logic [4:0]         dsum,
    output logic               bad
);
    logic [COORD_W-1:0] xmask;
    logic [COORD_W-1:0] ymask;
    int unsigned        dx;
    int unsigned        dy;

    always_comb begin
        dx    = drop_x(fmt, SWB);
        dy    = drop_y(fmt, SHB);
        xbits = 5'(CW - dx);
        ybits = 5'(CH - dy);
        dsum  = 5'(dx + dy);
        xmask = (COORD_W'(1) << xbits) - COORD_W'(1);
        ymask = (COORD_W'(1) << ybits) - COORD_W'(1);
        bad   = (x > xmask) || (y > ymask);
        x_m   = x[CW-1:0] ^ (orient[0] ? xmask[CW-1:0] : '0);
        y_m   = y[CH-1:0] ^ (orient[1] ? ymask[CH-1:0] : '0);
    end

endmodule

// File: rtl/tva_compose.sv
module tva_compose #(
    parameter int CW = 14,
    parameter int CH = 13
) (
    input  logic [1:0]    fmt,
    input  logic [2:0]    orient,
    input  logic [CW-1:0] x_m,
    input  logic [CH-1:0] y_m,
    input  logic [4:0]    xbits,
    input  logic [4:0]    ybits,
    input  logic [4:0]    dsum,
    input  logic          bad,
    output logic [31:0]   addr
);
    localparam int LIN_W = CW + CH;

    logic [LIN_W-1:0] xe;
    logic [LIN_W-1:0] ye;
    logic [LIN_W-1:0] off;
    logic [LIN_W-1:0] lin;

    always_comb begin
        xe   = {{(LIN_W-CW){1'b0}}, x_m};
        ye   = {{(LIN_W-CH){1'b0}}, y_m};
        off  = orient[2] ? ((xe << ybits) + ye) : ((ye << xbits) + xe);
        lin  = off << dsum;
        addr = bad ? 32'd0 : {orient, fmt, lin};
    end

endmodule

// File: rtl/tva_stride.sv
module tva_stride
    import tva_pkg::*;
#(
    parameter int CW  = 14,
    parameter int CH  = 13,
    parameter int SWB = 6,
    parameter int SHB = 6
) (
    input  logic [1:0]  fmt,
    input  logic        swap,
    output logic [31:0] stride
);
    int unsigned sh;

    always_comb begin
        sh     = swap ? (CH + drop_x(fmt, SWB)) : (CW + drop_y(fmt, SHB));
        stride = 32'd1 << sh;
    end

endmodule

// File: rtl/tva_addr_gen.sv
module tva_addr_gen
    import tva_pkg::*;
#(
    parameter int CW      = 14,
    parameter int CH      = 13,
    parameter int COORD_W = 16,
    parameter int SWB     = 6,
    parameter int SHB     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         fmt,
    input  logic [2:0]         orient,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic               out_valid,
    output logic [31:0]        addr,
    output logic               invalid,
    output logic [31:0]        stride
);
    st_e         state_q;
    st_e         state_d;
    logic [CW-1:0] x_m;
    logic [CH-1:0] y_m;
    logic [4:0]  xbits;
    logic [4:0]  ybits;
    logic [4:0]  dsum;
    logic        bad;
    logic [31:0] addr_d;
    logic [31:0] stride_d;

    tva_range #(.CW(CW), .CH(CH), .COORD_W(COORD_W), .SWB(SWB), .SHB(SHB)) u_range (
        .fmt(fmt), .orient(orient), .x(x), .y(y),
        .x_m(x_m), .y_m(y_m), .xbits(xbits), .ybits(ybits), .dsum(dsum), .bad(bad)
    );

    tva_compose #(.CW(CW), .CH(CH)) u_compose (
        .fmt(fmt), .orient(orient), .x_m(x_m), .y_m(y_m),
        .xbits(xbits), .ybits(ybits), .dsum(dsum), .bad(bad), .addr(addr_d)
    );

    tva_stride #(.CW(CW), .CH(CH), .SWB(SWB), .SHB(SHB)) u_stride (
        .fmt(fmt), .swap(orient[2]), .stride(stride_d)
    );

    // Next-state logic: accept / chain / drain.
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_EMIT : S_IDLE;
            S_EMIT:  state_d = in_valid ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on a request only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= 32'd0;
            invalid <= 1'b0;
            stride  <= 32'd0;
        end else if (in_valid) begin
            addr    <= addr_d;
            invalid <= bad;
            stride  <= stride_d;
        end
    end

    assign out_valid = (state_q == S_EMIT);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_fmt_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad) |=> (addr[28:27] == $past(fmt)));
    p_view_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad) |=> (addr[31:29] == $past(orient)));
    p_reject_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> (addr == 32'd0));
    p_stride_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(stride));
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(addr) && $stable(invalid) && $stable(stride)));

endmodule

// File: tb/tva_addr_gen_tb.sv
module tva_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [2:0]  orient = 3'd0;
    logic [15:0] x = 16'd0;
    logic [15:0] y = 16'd0;
    logic        out_valid;
    logic [31:0] addr;
    logic        invalid;
    logic [31:0] stride;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned last_a;

    always #2 clk = ~clk;

    tva_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
        .x(x), .y(y), .out_valid(out_valid), .addr(addr), .invalid(invalid), .stride(stride)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference from the requirements.
    task automatic model(input int f, input int o, input int xi, input int yi,
                         output int unsigned a, output int unsigned inv, output int unsigned s);
        int dx, dy, xw, yw, xm, ym, xx, yy;
        int unsigned off;
        dx = (f == 2) ? 1 : (f == 3) ? 6 : 0;
        dy = (f == 0) ? 0 : (f == 3) ? 6 : 1;
        xw = 14 - dx; yw = 13 - dy;
        xm = (1 << xw) - 1; ym = (1 << yw) - 1;
        s  = ((o & 4) != 0) ? (32'd1 << (13 + dx)) : (32'd1 << (14 + dy));
        if (xi > xm || yi > ym) begin
            a = 0; inv = 1;
        end else begin
            xx = ((o & 1) != 0) ? (xi ^ xm) : xi;
            yy = ((o & 2) != 0) ? (yi ^ ym) : yi;
            off = ((o & 4) != 0) ? int'(xx * (2 ** yw) + yy) : int'(yy * (2 ** xw) + xx);
            a = (int'(o) << 29) | (int'(f) << 27) | (off << (dx + dy));
            inv = 0;
        end
    endtask

    // Called at a negedge; leaves in_valid high, returns at the next negedge after checking.
    task automatic vec(input string tag, input int f, input int o, input int xi, input int yi);
        int unsigned ea, ei, es;
        model(f, o, xi, yi, ea, ei, es);
        fmt = 2'(f); orient = 3'(o); x = 16'(xi); y = 16'(yi);
        in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " R1 out_valid"}, 32'(out_valid), 1);
        chk({tag, " addr"}, addr, ea);
        chk({tag, " R4 invalid"}, 32'(invalid), ei);
        chk({tag, " R11 stride"}, stride, es);
        last_a = ea;
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        x = 16'hFFFF; y = 16'hFFFF; fmt = 2'd3; orient = 3'd7;
        @(negedge clk);
        chk({tag, " R1 no pulse"}, 32'(out_valid), 0);
        chk({tag, " R13 hold"}, addr, last_a);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 out_valid", 32'(out_valid), 0);
        chk("R12 addr", addr, 0);
        chk("R12 invalid", 32'(invalid), 0);
        chk("R12 stride", stride, 0);
        rst_n = 1'b1;
        @(negedge clk);
        last_a = 0;
        idle("R12 idle");

        // R2/R3/R8/R10: every format, plain view.
        for (int f = 0; f < 4; f++) vec("R2 R8 R10 fmt", f, 0, 37, 21);
        idle("after fmt");
        // R3/R6/R7/R9: every orientation on asymmetric coordinates.
        for (int o = 0; o < 8; o++) vec("R3 R6 R7 R9 view", 1, o, 101, 6);
        idle("after view");
        for (int o = 0; o < 8; o++) vec("R3 R6 R7 R9 view32", 2, o, 3000, 17);
        idle("after view32");
        // R5/R4: boundaries per format.
        for (int f = 0; f < 4; f++) begin
            int dx, dy, xm, ym;
            dx = (f == 2) ? 1 : (f == 3) ? 6 : 0;
            dy = (f == 0) ? 0 : (f == 3) ? 6 : 1;
            xm = (1 << (14 - dx)) - 1; ym = (1 << (13 - dy)) - 1;
            vec("R5 max", f, 0, xm, ym);
            vec("R5 R6 R7 max mirrored", f, 3, xm, ym);
            vec("R4 x over", f, 0, xm + 1, 0);
            vec("R4 y over", f, 4, 0, ym + 1);
            vec("R5 zero swapped", f, 7, 0, 0);
            idle("after bounds");
        end
        vec("R4 both over", 0, 5, 16'hFFFF, 16'hFFFF);
        idle("R13 after reject");
        idle("R13 second idle");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule